// File: doc/BRIEF.md
# Saturating float-to-fixed vector converter

This block turns one 128-bit vector holding four single-precision floating-point lanes into four 32-bit fixed-point integers in a single operation. Each lane is scaled by two raised to a 5-bit unsigned shift count. It is then cut toward zero to an integer. A mode input picks a signed or an unsigned result. Lanes that do not fit are clamped to the limit of the chosen range. Whenever any lane had to be clamped, or was not a number, one saturation flag goes out with the result. Software merges that flag into its own sticky status.

Tiny inputs whose exponent field is zero count as zero before scaling, keeping their sign. Infinities clamp like any other oversized value. A not-a-number lane clamps to the most negative integer in signed mode and to zero in unsigned mode. Requests arrive on a valid/ready handshake. The result is held in an output register, one cycle after acceptance, until the consumer takes it.

Top module: `fx_vec_cvt`

## Requirements
- R1: In signed mode (in_signed=1) a lane whose exponent field is all ones and whose fraction is nonzero (NaN) yields 32'h80000000 and sets out_sat.
- R2: In unsigned mode (in_signed=0) a NaN lane yields 32'h00000000 and sets out_sat.
- R3: A lane with exponent field zero (zero or subnormal, either sign) yields 0 and does not set out_sat, in both modes and for any scale.
- R4: The value of a lane is multiplied by 2^in_scale before conversion, with in_scale from 0 to 31 (for example 1.5 with scale 4 yields 24).
- R5: An in-range result is truncated toward zero, so -2.75 yields -2 and 0.75 yields 0 in signed mode, without setting out_sat.
- R6: In signed mode a scaled value of 2^31-1 or more yields 32'h7FFFFFFF and a value of -2^31 or less yields 32'h80000000, both setting out_sat.
- R7: In unsigned mode any negative nonzero scaled value yields 0 and a value above 2^32-1 yields 32'hFFFFFFFF, both setting out_sat; 2^31 converts exactly without saturation.
- R8: +infinity yields 32'h7FFFFFFF (signed) or 32'hFFFFFFFF (unsigned); -infinity yields 32'h80000000 (signed) or 0 (unsigned); all set out_sat.
- R9: Lane 0 occupies bits 127:96 of both in_vec and out_data, lane 3 bits 31:0; out_sat is the OR of the four lanes' saturation.
- R10: An accepted request appears on out_data/out_sat with out_valid one clock edge later; in_ready is high exactly when out_valid is low or out_ready is high; a result not taken holds stable.
- R11: After reset out_valid, out_data and out_sat are zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_vec | input | 128 | Four float lanes, lane 0 in the top bits |
| in_scale | input | 5 | Power-of-two scale applied before conversion |
| in_signed | input | 1 | 1 selects signed results, 0 unsigned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Four 32-bit integer lanes, lane 0 in the top bits |
| out_sat | output | 1 | Some lane was clamped or was NaN |

## Verification
The output register can hand a result to the consumer and load the next request on the same clock edge. The bench provokes this by stalling out_ready with one result held while a second request waits. It then raises out_ready with the second request still valid. It judges that in_ready rises at once, the held result stays stable through the stall, and the very next cycle shows the second result with no empty cycle between. The lane converters, fed with random float patterns and directed limits, are compared against a real-arithmetic model in the bench.

// File: rtl/fx_cvt_pkg.sv
package fx_cvt_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int SIG_W = MAN_W + 1;
  localparam int BIAS  = 127;
  localparam int KW    = 10;

  localparam logic [FP_W-1:0] S_MAX = 32'h7FFF_FFFF;
  localparam logic [FP_W-1:0] S_MIN = 32'h8000_0000;
  localparam logic [FP_W-1:0] U_MAX = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_e;
endpackage

// File: rtl/fx_float_class.sv
module fx_float_class
  import fx_cvt_pkg::*;
(
  input  logic [FP_W-1:0]  f,
  output fcls_e            cls,
  output logic             neg,
  output logic [EXP_W-1:0] expo,
  output logic [SIG_W-1:0] sig
);
  logic exp_ones, exp_zero, frac_nz;

  always_comb begin
    neg      = f[FP_W-1];
    expo     = f[FP_W-2 -: EXP_W];
    exp_ones = &expo;
    exp_zero = ~|expo;
    frac_nz  = |f[MAN_W-1:0];
    sig      = {1'b1, f[MAN_W-1:0]};
    if (exp_ones)      cls = frac_nz ? CLS_NAN : CLS_INF;
    else if (exp_zero) cls = CLS_ZERO;
    else               cls = CLS_NORM;
  end
endmodule

// File: rtl/fx_lane_cvt.sv
module fx_lane_cvt
  import fx_cvt_pkg::*;
#(
  parameter int SCALE_W = 5
) (
  input  logic [FP_W-1:0]    f,
  input  logic [SCALE_W-1:0] scale,
  input  logic               sgn_mode,
  output logic [FP_W-1:0]    q,
  output logic               sat
);
  fcls_e            cls;
  logic             neg;
  logic [EXP_W-1:0] expo;
  logic [SIG_W-1:0] sig;

  fx_float_class u_cls (
    .f   (f),
    .cls (cls),
    .neg (neg),
    .expo(expo),
    .sig (sig)
  );

  logic signed [KW-1:0] k;
  logic [4:0]           shamt;
  logic [FP_W-1:0]      mag;

  always_comb begin
    k     = $signed({{(KW-EXP_W){1'b0}}, expo}) - KW'(BIAS)
          + $signed({{(KW-SCALE_W){1'b0}}, scale});
    shamt = 5'd31 - k[4:0];
    mag   = {sig, {(FP_W-SIG_W){1'b0}}} >> shamt;
  end

  always_comb begin
    q   = '0;
    sat = 1'b0;
    unique case (cls)
      CLS_NAN: begin
        q   = sgn_mode ? S_MIN : '0;
        sat = 1'b1;
      end
      CLS_INF: begin
        if (sgn_mode) q = neg ? S_MIN : S_MAX;
        else          q = neg ? '0 : U_MAX;
        sat = 1'b1;
      end
      CLS_ZERO: begin
        q   = '0;
        sat = 1'b0;
      end
      default: begin
        if (!sgn_mode && neg) begin
          q   = '0;
          sat = 1'b1;
        end else if (sgn_mode && k >= KW'(31)) begin
          q   = neg ? S_MIN : S_MAX;
          sat = 1'b1;
        end else if (!sgn_mode && k >= KW'(32)) begin
          q   = U_MAX;
          sat = 1'b1;
        end else if (k < 0) begin
          q   = '0;
        end else begin
          q   = neg ? (~mag + 1'b1) : mag;
        end
      end
    endcase
  end
endmodule

// File: rtl/fx_out_stage.sv
module fx_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] d_in,
  input  logic              s_in,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] d_out,
  output logic              s_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      d_out <= '0;
      s_out <= 1'b0;
    end else if (push) begin
      full  <= 1'b1;
      d_out <= d_in;
      s_out <= s_in;
    end else if (pop) begin
      full  <= 1'b0;
    end
  end
endmodule

// File: rtl/fx_vec_cvt.sv
module fx_vec_cvt
  import fx_cvt_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SCALE_W   = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NUM_LANES*FP_W-1:0] in_vec,
  input  logic [SCALE_W-1:0]        in_scale,
  input  logic                      in_signed,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NUM_LANES*FP_W-1:0] out_data,
  output logic                      out_sat
);
  localparam int VEC_W = NUM_LANES * FP_W;

  logic [VEC_W-1:0]     conv;
  logic [NUM_LANES-1:0] lane_sat;
  logic                 push;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    fx_lane_cvt #(.SCALE_W(SCALE_W)) u_lane (
      .f       (in_vec[VEC_W-1-FP_W*i -: FP_W]),
      .scale   (in_scale),
      .sgn_mode(in_signed),
      .q       (conv[VEC_W-1-FP_W*i -: FP_W]),
      .sat     (lane_sat[i])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign push     = in_valid && in_ready;

  fx_out_stage #(.DATA_W(VEC_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .d_in (conv),
    .s_in (|lane_sat),
    .pop  (out_ready),
    .full (out_valid),
    .d_out(out_data),
    .s_out(out_sat)
  );
endmodule

// File: rtl/fx_vec_cvt_chk.sv
module fx_vec_cvt_chk #(
  parameter int NUM_LANES = 4,
  parameter int SCALE_W   = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [NUM_LANES*32-1:0]   in_vec,
  input logic [SCALE_W-1:0]        in_scale,
  input logic                      in_signed,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [NUM_LANES*32-1:0]   out_data,
  input logic                      out_sat
);
  localparam int VEC_W = NUM_LANES * 32;

  logic [31:0] l0_in, l0_out;
  logic        acc, l0_nan, l0_tiny, l0_one;
  assign l0_in   = in_vec[VEC_W-1 -: 32];
  assign l0_out  = out_data[VEC_W-1 -: 32];
  assign acc     = in_valid && in_ready;
  assign l0_nan  = (&l0_in[30:23]) && (|l0_in[22:0]);
  assign l0_tiny = ~|l0_in[30:23];
  assign l0_one  = (l0_in == 32'h3F80_0000);

  AST_NAN_SIGNED: assert property (@(posedge clk) disable iff (rst)
    acc && in_signed && l0_nan |=> l0_out == 32'h8000_0000 && out_sat); // R1
  AST_NAN_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
    acc && !in_signed && l0_nan |=> l0_out == 32'h0 && out_sat); // R2
  AST_TINY_FLUSH: assert property (@(posedge clk) disable iff (rst)
    acc && l0_tiny |=> l0_out == 32'h0); // R3
  AST_ONE_SCALED: assert property (@(posedge clk) disable iff (rst)
    acc && !in_signed && l0_one |=> l0_out == (32'd1 << $past(in_scale))); // R4
  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sat)); // R10
  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R10
endmodule

bind fx_vec_cvt fx_vec_cvt_chk #(.NUM_LANES(NUM_LANES), .SCALE_W(SCALE_W)) u_chk (.*);

// File: tb/sim_fx_vec_cvt.sv
module sim_fx_vec_cvt;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, in_signed, out_valid, out_ready, out_sat;
  logic [127:0] in_vec, out_data;
  logic [4:0]   in_scale;
  int           total = 0;
  int           bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_vec_cvt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_scale(in_scale), .in_signed(in_signed),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat)
  );

  function automatic logic [32:0] ref_lane(logic [31:0] f, int sc, bit sm);
    int  e = int'(f[30:23]);
    real v;
    if (e == 255 && f[22:0] != 0) return sm ? {1'b1, 32'h8000_0000} : {1'b1, 32'h0};
    if (e == 255) begin
      if (sm) return {1'b1, f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF};
      return {1'b1, f[31] ? 32'h0 : 32'hFFFF_FFFF};
    end
    if (e == 0) return 33'h0;
    v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** real'(e - 127 + sc));
    if (f[31]) v = -v;
    if (sm) begin
      if (v >= 2147483647.0)  return {1'b1, 32'h7FFF_FFFF};
      if (v <= -2147483648.0) return {1'b1, 32'h8000_0000};
      return {1'b0, 32'($rtoi(v))};
    end
    if (v < 0.0) return {1'b1, 32'h0};
    if (v > 4294967295.0) return {1'b1, 32'hFFFF_FFFF};
    if (v >= 2147483648.0) return {1'b0, 32'h8000_0000 + 32'($rtoi(v - 2147483648.0))};
    return {1'b0, 32'($rtoi(v))};
  endfunction

  function automatic logic [128:0] ref_vec(logic [127:0] v, int sc, bit sm);
    logic [128:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      logic [32:0] l = ref_lane(v[127-32*i -: 32], sc, sm);
      r[127-32*i -: 32] = l[31:0];
      r[128] = r[128] | l[32];
    end
    return r;
  endfunction

  function automatic logic [31:0] rand_lane();
    int c = int'($urandom % 8);
    logic [31:0] r = $urandom;
    case (c)
      0: r[30:23] = 8'hFF;
      1: r[30:0]  = {8'hFF, 23'h0};
      2: r[30:23] = 8'h00;
      default: r[30:23] = 8'(100 + ($urandom % 70));
    endcase
    if (c == 0 && r[22:0] == 0) r[0] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(string req, logic [127:0] v, logic [4:0] sc, bit sm);
    logic [128:0] e = ref_vec(v, int'(sc), sm);
    @(negedge clk);
    in_vec = v; in_scale = sc; in_signed = sm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " data"}, out_data, e[127:0]);
    check({req, " sat"}, {127'h0, out_sat}, {127'h0, e[128]});
    check("R10 valid", {127'h0, out_valid}, 128'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [128:0] ea, eb;
    logic [127:0] va, vb;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 0; out_ready = 1; in_vec = '0; in_scale = '0; in_signed = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset", {out_data[126:0], out_valid}, 128'h0);
    check("R11 reset sat/ready", {126'h0, out_sat, in_ready}, 128'h1);

    // R1, R9: NaN in lane 0, ones elsewhere
    send("R1", {32'h7FC0_0001, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, 5'd0, 1);
    check("R1 literal", out_data, {32'h8000_0000, 32'd1, 32'd1, 32'd1});
    // R2: unsigned NaN in lane 2
    send("R2", {32'h3F80_0000, 32'h4000_0000, 32'hFF80_0001, 32'h3F80_0000}, 5'd1, 0);
    check("R2 literal", out_data, {32'd2, 32'd4, 32'd0, 32'd2});
    // R3: subnormals of both signs, big scale, both modes
    send("R3 unsigned", {32'h8000_0001, 32'h0040_0000, 32'h8000_0000, 32'h0000_0000}, 5'd31, 0);
    check("R3 literal", {127'h0, out_sat}, 128'h0);
    send("R3 signed", {32'h807F_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h0040_0000}, 5'd31, 1);
    // R4, R5: scaling and truncation toward zero
    send("R4", {32'h3FC0_0000, 32'h3FC0_0000, 32'h3F80_0000, 32'h4120_0000}, 5'd4, 1);
    check("R4 literal", out_data[127:96], 32'd24);
    send("R5", {32'hC030_0000, 32'h3F40_0000, 32'hBF40_0000, 32'h4030_0000}, 5'd0, 1);
    check("R5 literal", out_data, {32'hFFFF_FFFE, 32'd0, 32'd0, 32'd2});
    // R6: signed limits, including exactly -2^31
    send("R6", {32'h3F80_0000, 32'hBF80_0000, 32'h3F7F_FFFF, 32'hBF7F_FFFF}, 5'd31, 1);
    check("R6 literal", out_data[127:64], {32'h7FFF_FFFF, 32'h8000_0000});
    // R7: unsigned limits
    send("R7", {32'h3F80_0000, 32'hBF00_0000, 32'h4F80_0000, 32'h4F7F_FFFF}, 5'd31, 0);
    send("R7 exact", {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, 5'd31, 0);
    check("R7 literal", {out_data[127:96], 95'h0, out_sat}, {32'h8000_0000, 96'h0});
    // R8: infinities
    send("R8 signed", {32'h7F80_0000, 32'hFF80_0000, 32'h0, 32'h0}, 5'd3, 1);
    send("R8 unsigned", {32'h7F80_0000, 32'hFF80_0000, 32'h0, 32'h0}, 5'd3, 0);
    check("R8 literal", out_data[127:64], {32'hFFFF_FFFF, 32'h0});
    // R9: lane order and OR of sat from lane 3 alone
    send("R9", {32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 32'h7F80_0000}, 5'd0, 1);
    check("R9 literal", {out_data[127:32], 31'h0, out_sat}, {32'd1, 32'd2, 32'd3, 32'h1});

    // R10: stall, hold, then drain and accept on the same edge
    va = {32'h4000_0000, 32'hC000_0000, 32'h0, 32'h3F80_0000};
    vb = {32'h4080_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'h0};
    ea = ref_vec(va, 2, 1); eb = ref_vec(vb, 2, 1);
    @(negedge clk);
    out_ready = 0; in_vec = va; in_scale = 5'd2; in_signed = 1; in_valid = 1;
    @(negedge clk);
    check("R10 first", out_data, ea[127:0]);
    check("R10 ready low", {127'h0, in_ready}, 128'h0);
    in_vec = vb;
    @(negedge clk);
    check("R10 hold", {out_data[126:0], out_valid}, {ea[126:0], 1'b1});
    out_ready = 1;
    #1 check("R10 ready rises", {127'h0, in_ready}, 128'h1);
    @(negedge clk);
    in_valid = 0;
    check("R10 second", out_data, eb[127:0]);
    check("R10 second sat", {127'h0, out_sat}, {127'h0, eb[128]});
    @(negedge clk);
    check("R10 drained", {127'h0, out_valid}, 128'h0);

    // random mix against the model
    for (int n = 0; n < 300; n++) begin
      logic [127:0] rv = {rand_lane(), rand_lane(), rand_lane(), rand_lane()};
      send("R4 random", rv, 5'($urandom % 32), bit'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule